// File: doc/BRIEF.md
# Iterative Shift-Add Integer Multiplier

This block multiplies two 32-bit integers over many clock cycles with a single 32-bit adder. It returns the 64-bit product as two words: an upper word and a lower word. A single-cycle request pulse starts an operation and supplies both operands and a mode bit. The mode bit selects unsigned or two's-complement interpretation. The block then reports that it is busy until a one-cycle completion pulse appears. At that point the result words are valid, and they stay unchanged until the next completion.

Internally, the block holds a 64-bit accumulator whose lower half starts out holding the second operand. Each step inspects the accumulator's least significant bit and may add the first operand into the upper half. The step then shifts the whole accumulator right, including the adder's carry. In signed mode, the block first reduces both operands to magnitudes and negates the final product when exactly one operand was negative. A flag reports whether the product would fit in a single 32-bit word under the selected interpretation.

Top module: `seq_mult`

## Requirements
- R1: While reset is high, and on the first cycle after it, busy, done, the overflow flag and both result words are all zero.
- R2: In unsigned mode (mode bit 0), {hi, lo} equals the exact 64-bit product of the two operands read as unsigned numbers.
- R3: In signed mode (mode bit 1), {hi, lo} equals the exact two's-complement 64-bit product. This includes operands equal to the most negative 32-bit value, whose magnitude is 2^31.
- R4: The done pulse appears after the 33rd rising edge that follows the edge that accepted the start. Busy is high throughout those 33 cycles and is low whenever done is high.
- R5: Done is high for exactly one cycle per accepted operation.
- R6: A start pulse that arrives while busy is high is ignored. The running operation finishes on its original schedule with its original operands' product.
- R7: In unsigned mode, the overflow flag is set exactly when hi is nonzero.
- R8: In signed mode, the overflow flag is set exactly when some bit of hi differs from bit 31 of lo.
- R9: hi, lo and the overflow flag change only in the cycle in which done is high.
- R10: A start pulse sampled while idle makes busy high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse; accepted only while idle |
| op_a_i | input | 32 | Multiplicand operand |
| op_b_i | input | 32 | Multiplier operand |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Upper word of the product |
| lo_o | output | 32 | Lower word of the product |
| ovf_o | output | 1 | Product does not fit in one 32-bit word |

## Verification
The hardest situation to reach from the ports is a second request that lands in the middle of an operation. Its operands differ from those of the running operation, so a wrongly accepted request would corrupt both the result and the timing. The stimulus raises start for one cycle deep inside a run, then checks the completion cycle count and the original product. A second difficult situation is the most negative operand, whose magnitude needs the full unsigned range. This is exercised alone, squared, and against minus one.

// File: rtl/mul_pkg.sv
package mul_pkg;

    localparam int DEF_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mul_state_t;

    typedef struct packed {
        logic sgn;   // operation interprets operands as two's complement
        logic neg;   // final product must be negated
    } mul_mode_t;

endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sgn_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_o
);
    logic [1:0][W-1:0] raw;
    logic [1:0][W-1:0] mag;
    logic [1:0]        is_neg;

    assign raw[0] = a_i;
    assign raw[1] = b_i;

    for (genvar g = 0; g < 2; g++) begin : g_op
        // Negating the most negative value yields 2^(W-1) read as unsigned.
        assign is_neg[g] = sgn_i & raw[g][W-1];
        assign mag[g]    = is_neg[g] ? (~raw[g] + 1'b1) : raw[g];
    end

    assign mag_a_o = mag[0];
    assign mag_b_o = mag[1];
    assign neg_o   = is_neg[0] ^ is_neg[1];
endmodule

// File: rtl/mul_step_unit.sv
module mul_step_unit #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   mcand_i,
    output logic [2*W-1:0] acc_o
);
    logic [W:0] upper_sum;

    always_comb begin
        if (acc_i[0]) begin
            upper_sum = {1'b0, acc_i[2*W-1:W]} + {1'b0, mcand_i};
        end else begin
            upper_sum = {1'b0, acc_i[2*W-1:W]};
        end
        // carry of the add enters the top bit during the shift
        acc_o = {upper_sum, acc_i[W-1:1]};
    end
endmodule

// File: rtl/mul_result_fix.sv
module mul_result_fix #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc_i,
    input  logic           neg_i,
    input  logic           sgn_i,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o,
    output logic           ovf_o
);
    logic [2*W-1:0] fixed;

    always_comb begin
        fixed = neg_i ? (~acc_i + 1'b1) : acc_i;
        hi_o  = fixed[2*W-1:W];
        lo_o  = fixed[W-1:0];
        if (sgn_i) begin
            ovf_o = (hi_o != {W{lo_o[W-1]}});
        end else begin
            ovf_o = (hi_o != '0);
        end
    end
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
    parameter int WIDTH = mul_pkg::DEF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic             signed_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o,
    output logic             ovf_o
);
    import mul_pkg::*;

    localparam int ACC_W = 2 * WIDTH;
    localparam int CNT_W = $clog2(WIDTH) + 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    mul_state_t       state_q;
    mul_mode_t        mode_q;
    logic [CNT_W-1:0] step_q;
    logic [ACC_W-1:0] acc_q;
    logic [WIDTH-1:0] mcand_q;

    logic [WIDTH-1:0] mag_a, mag_b;
    logic             neg_c;
    logic [ACC_W-1:0] acc_nxt;
    logic [WIDTH-1:0] hi_c, lo_c;
    logic             ovf_c;
    logic             accept;

    assign accept = start_i && (state_q == ST_IDLE);

    mul_operand_prep #(.W(WIDTH)) u_prep (
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .sgn_i   (signed_i),
        .mag_a_o (mag_a),
        .mag_b_o (mag_b),
        .neg_o   (neg_c)
    );

    mul_step_unit #(.W(WIDTH)) u_step (
        .acc_i   (acc_q),
        .mcand_i (mcand_q),
        .acc_o   (acc_nxt)
    );

    mul_result_fix #(.W(WIDTH)) u_fix (
        .acc_i (acc_q),
        .neg_i (mode_q.neg),
        .sgn_i (mode_q.sgn),
        .hi_o  (hi_c),
        .lo_o  (lo_c),
        .ovf_o (ovf_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            step_q  <= '0;
            acc_q   <= '0;
            mcand_q <= '0;
            done_o  <= 1'b0;
            hi_o    <= '0;
            lo_o    <= '0;
            ovf_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        acc_q   <= {{WIDTH{1'b0}}, mag_b};
                        mcand_q <= mag_a;
                        mode_q  <= '{sgn: signed_i, neg: neg_c};
                        step_q  <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    acc_q  <= acc_nxt;
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP) begin
                        state_q <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    hi_o    <= hi_c;
                    lo_o    <= lo_c;
                    ovf_o   <= ovf_c;
                    done_o  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o,
    input logic             ovf_o,
    input logic             sgn_i
);
    localparam int BC_W = $clog2(WIDTH + 2) + 1;

    logic [BC_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (start_i && !busy_o) begin
            busy_cnt <= '0;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !done_o && !ovf_o && hi_o == '0 && lo_o == '0));

    p_done_latency_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_cnt == BC_W'(WIDTH + 1) && !busy_o));

    p_busy_end_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(hi_o) && $stable(lo_o) && $stable(ovf_o)));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !sgn_i) |-> (ovf_o == (hi_o != '0)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && sgn_i) |-> (ovf_o == (hi_o != {WIDTH{lo_o[WIDTH-1]}})));
endmodule

bind seq_mult seq_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o),
    .ovf_o   (ovf_o),
    .sgn_i   (mode_q.sgn)
);

// File: tb/seq_mult_tb.sv
module seq_mult_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic        signed_i = 1'b0;
    logic        busy_o, done_o, ovf_o;
    logic [31:0] hi_o, lo_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    seq_mult u_dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .signed_i(signed_i),
        .busy_o(busy_o), .done_o(done_o),
        .hi_o(hi_o), .lo_o(lo_o), .ovf_o(ovf_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input logic s);
        longint sa, sb;
        if (s) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        return {32'b0, a} * {32'b0, b};
    endfunction

    function automatic logic ref_ovf(input logic [63:0] p, input logic s);
        if (s) return p[63:32] != {32{p[31]}};
        return p[63:32] != 32'b0;
    endfunction

    // Issue one operation; optionally pulse start again mid-run with other operands.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                          input bit inject, input string req);
        logic [63:0] exp_p;
        int cycles;
        exp_p = ref_prod(a, b, s);
        @(negedge clk);
        op_a_i = a; op_b_i = b; signed_i = s; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        op_a_i = ~a; op_b_i = b + 32'd7; signed_i = ~s;
        check("R10 busy after accept", {63'b0, busy_o}, 64'd1);
        cycles = 0;
        do begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            if (inject && cycles == 10) start_i = 1'b1;
            if (inject && cycles == 11) start_i = 1'b0;
            if (!done_o && cycles < 33) check("R4 busy during run", {63'b0, busy_o}, 64'd1);
        end while (!done_o && cycles < 100);
        check({req, " latency R4"}, 64'(cycles), 64'd33);
        check("R4 busy low at done", {63'b0, busy_o}, 64'd0);
        check({req, " product"}, {hi_o, lo_o}, exp_p);
        check(s ? "R8 overflow flag" : "R7 overflow flag", {63'b0, ovf_o}, {63'b0, ref_ovf(exp_p, s)});
        @(negedge clk);
        check("R5 done single cycle", {63'b0, done_o}, 64'd0);
        check("R9 result held", {hi_o, lo_o}, exp_p);
        if (inject) check("R6 restart ignored, idle after", {63'b0, busy_o}, 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset busy/done", {62'b0, busy_o, done_o}, 64'd0);
        check("R1 reset result", {hi_o, lo_o}, 64'd0);
        check("R1 reset ovf", {63'b0, ovf_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {61'b0, busy_o, done_o, ovf_o}, 64'd0);
    endtask

    task automatic t_unsigned;
        run_op(32'd3, 32'd5, 1'b0, 0, "R2");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, "R2");
        run_op(32'd0, 32'hDEAD_BEEF, 1'b0, 0, "R2");
        run_op(32'h0001_0000, 32'h0001_0000, 1'b0, 0, "R2 R7");
        run_op(32'd1, 32'h7FFF_FFFF, 1'b0, 0, "R2 R7");
    endtask

    task automatic t_signed;
        run_op(32'hFFFF_FFFD, 32'd5, 1'b1, 0, "R3");
        run_op(-32'sd7, -32'sd9, 1'b1, 0, "R3");
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 0, "R3 R8");
        run_op(32'h8000_0000, 32'd1, 1'b1, 0, "R3 R8");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0, "R3 R8");
        run_op(32'd12345, 32'hFFFF_FFFF, 1'b1, 0, "R3 R8");
        run_op(32'h0001_0000, 32'hFFFF_0000, 1'b1, 0, "R3 R8");
    endtask

    task automatic t_restart;
        run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1, "R6");
        run_op(32'hF000_000F, 32'h0000_0101, 1'b1, 1, "R6");
    endtask

    task automatic t_hold;
        logic [63:0] snap;
        snap = {hi_o, lo_o};
        repeat (5) @(negedge clk);
        check("R9 idle hold", {hi_o, lo_o}, snap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_restart();
        t_hold();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule